// File: doc/BRIEF.md
# Multiprocessor Masked Interrupt Distributor

The block takes a 64-bit vector of device interrupt requests and distributes it to four processors. One shared pending register collects requests. Each processor owns a 64-bit enable mask and a 64-bit masked status register, and the block drives one interrupt line per processor. Set and clear inputs change the pending vector, and every processor's status follows in the same cycle.

Software reaches the block through a register port that accepts only full 64-bit accesses. The port reads and writes the masks, reads the status and pending registers, and reads a miscellaneous register. That register returns the caller's processor number in its low bits and carries a timer interrupt flag. Software clears the flag by writing that register. Every request gets a registered response one cycle later, with an error flag for illegal accesses.

Top module: `irq_dist`

## Requirements
- R1: A processor's status only ever holds bits that are also pending. Register index i (0..3) is mask i, index 4+i is status i, and index 8 is the pending vector; all of these are readable.
- R2: `cpu_irq_o[i]` is high exactly when status i is nonzero. Once high, it stays high until a clear removes the last remaining status bit.
- R3: On a clock edge with `set_i` nonzero, the set bits are ORed into pending. The set bits that a processor's (new) mask enables are ORed into that processor's status.
- R4: On a clock edge, `clr_i` bits are removed from pending and from every status. Where the same bit is set and cleared in one cycle, the clear wins.
- R5: A legal write to index 0..3 replaces that mask. If the new mask overlaps the pending vector, the status becomes mask AND pending; otherwise the status is kept.
- R6: The register index is address bits [9:6]. Address bits [5:0] and the bits above bit 9 are ignored.
- R7: A read of index 9 returns the timer flag in bit 4 and `req_cpu_i` in bits [1:0]; all other bits are zero. A `timer_evt_i` pulse sets the flag, and `timer_irq_o` follows it.
- R8: A write to index 9 with data bit 4 set clears the timer flag, unless `timer_evt_i` is high in the same cycle. A write to index 9 with bit 4 clear is an error.
- R9: Any access whose `req_size_i` (byte count) is not 8 is an error.
- R10: Writes to status or pending indices (4..8) are errors, and so is any access to index 10..15.
- R11: An error response has zero read data, and the failing access changes no state.
- R12: Each cycle with `req_valid_i` high produces exactly one response with `rsp_valid_o` high in the next cycle. Read data reflects the state before that edge.
- R13: After reset, masks, statuses, pending, the timer flag, all interrupt lines and the response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address; bits [9:6] select the register |
| req_size_i | input | 4 | Access size in bytes; only 8 is legal |
| req_wdata_i | input | 64 | Write data |
| req_cpu_i | input | 2 | Number of the requesting processor |
| set_i | input | 64 | Request bits to raise this cycle |
| clr_i | input | 64 | Request bits to drop this cycle |
| timer_evt_i | input | 1 | Timer tick pulse; sets the timer flag |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_err_o | output | 1 | Access error |
| rsp_rdata_o | output | 64 | Read data, zero on error or write |
| cpu_irq_o | output | 4 | Interrupt line per processor |
| timer_irq_o | output | 1 | Timer interrupt line |

## Verification
Several events can land on the same edge: a mask write, a set vector and a clear vector. A clear of the timer flag can also land on the same edge as a new timer tick. Directed cycles drive a mask write together with a set pulse, a set and a clear of the same bit, and a timer flag clear during a tick. A long random phase then overlaps all of these freely. A behavioural model in the bench applies the stated precedence: the new mask governs set bits, clear beats set, and a tick beats a flag clear. The bench compares the interrupt lines and every response against that model on each clock.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned NCPU      = 4;
  localparam int unsigned CPU_ID_W  = $clog2(NCPU);
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned IDX_LSB   = 6;
  localparam int unsigned TIMER_BIT = 4;

  localparam logic [3:0]       ACC_BYTES     = 4'd8;
  localparam logic [IDX_W-1:0] IDX_STAT_BASE = IDX_W'(NCPU);
  localparam logic [IDX_W-1:0] IDX_PEND      = IDX_W'(2 * NCPU);
  localparam logic [IDX_W-1:0] IDX_MISC      = IDX_W'(2 * NCPU + 1);

  typedef enum logic [2:0] {
    ACC_MASK,
    ACC_STAT,
    ACC_PEND,
    ACC_MISC,
    ACC_BAD
  } acc_kind_e;
endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                valid_i,
  input  logic                write_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [3:0]          size_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output acc_kind_e           kind_o,
  output logic [CPU_ID_W-1:0] sel_o,
  output logic                err_o
);
  logic [IDX_W-1:0] idx;
  assign idx   = addr_i[IDX_LSB +: IDX_W];
  assign sel_o = idx[CPU_ID_W-1:0];

  always_comb begin
    if (idx < IDX_STAT_BASE)  kind_o = ACC_MASK;
    else if (idx < IDX_PEND)  kind_o = ACC_STAT;
    else if (idx == IDX_PEND) kind_o = ACC_PEND;
    else if (idx == IDX_MISC) kind_o = ACC_MISC;
    else                      kind_o = ACC_BAD;
  end

  always_comb begin
    err_o = 1'b0;
    if (valid_i) begin
      if (size_i != ACC_BYTES)                               err_o = 1'b1;
      else if (kind_o == ACC_BAD)                            err_o = 1'b1;
      else if (write_i && (kind_o inside {ACC_STAT, ACC_PEND})) err_o = 1'b1;
      else if (write_i && kind_o == ACC_MISC && !wdata_i[TIMER_BIT]) err_o = 1'b1;
    end
  end
endmodule

// File: rtl/irq_dist_slice.sv
module irq_dist_slice
  import irq_dist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic [DATA_W-1:0] pend_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_d, base, status_d, overlap;

  assign overlap  = mask_wdata_i & pend_i;
  assign mask_d   = mask_we_i ? mask_wdata_i : mask_o;
  // mask write reloads status only when it hits pending requests
  assign base     = (mask_we_i && (overlap != '0)) ? overlap : status_o;
  assign status_d = (base | (set_i & mask_d)) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      mask_o   <= mask_d;
      status_o <= status_d;
      irq_o    <= (status_d != '0);
    end
  end

  // R4
  clr_removes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_o & $past(clr_i)) == '0));

  // R3
  set_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_we_i && ((set_i & mask_o & ~clr_i) != '0)) |=> irq_o);

  // R2
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && clr_i == '0) |=> irq_o);
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [3:0]          req_size_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [CPU_ID_W-1:0] req_cpu_i,
  input  logic [DATA_W-1:0]   set_i,
  input  logic [DATA_W-1:0]   clr_i,
  input  logic                timer_evt_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [NCPU-1:0]     cpu_irq_o,
  output logic                timer_irq_o
);
  acc_kind_e           kind;
  logic [CPU_ID_W-1:0] sel;
  logic                err, acc_ok, misc_clr;
  logic [DATA_W-1:0]   pend_q, rd, misc_rd;
  logic [DATA_W-1:0]   mask_w [NCPU];
  logic [DATA_W-1:0]   stat_w [NCPU];

  irq_dist_decode #(.ADDR_W(ADDR_W)) i_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .wdata_i (req_wdata_i),
    .kind_o  (kind),
    .sel_o   (sel),
    .err_o   (err)
  );

  assign acc_ok   = req_valid_i && !err;
  assign misc_clr = acc_ok && req_write_i && (kind == ACC_MISC);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irq_dist_slice i_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .set_i        (set_i),
      .clr_i        (clr_i),
      .pend_i       (pend_q),
      .mask_we_i    (acc_ok && req_write_i && kind == ACC_MASK && sel == CPU_ID_W'(c)),
      .mask_wdata_i (req_wdata_i),
      .mask_o       (mask_w[c]),
      .status_o     (stat_w[c]),
      .irq_o        (cpu_irq_o[c])
    );

    // R1
    stat_in_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_w[c] & ~pend_q) == '0);
  end

  always_comb begin
    misc_rd = '0;
    misc_rd[TIMER_BIT] = timer_irq_o;
    misc_rd[CPU_ID_W-1:0] = req_cpu_i;
  end

  always_comb begin
    unique case (kind)
      ACC_MASK: rd = mask_w[sel];
      ACC_STAT: rd = stat_w[sel];
      ACC_PEND: rd = pend_q;
      ACC_MISC: rd = misc_rd;
      default:  rd = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      timer_irq_o <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      pend_q      <= (pend_q | set_i) & ~clr_i;
      // a new tick beats a software clear
      timer_irq_o <= timer_evt_i | (timer_irq_o & ~misc_clr);
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= err;
      rsp_rdata_o <= (acc_ok && !req_write_i) ? rd : '0;
    end
  end

  // R11
  err_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_rdata_o == '0));

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R7
  timer_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_evt_i |=> timer_irq_o);

  // R8
  timer_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_clr && !timer_evt_i) |=> !timer_irq_o);
endmodule

// File: tb/test_irq_dist.sv
module test_irq_dist;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_cpu = '0;
  logic [63:0] set_v = '0, clr_v = '0;
  logic        tevt = 1'b0;
  logic        rsp_valid, rsp_err, timer_irq;
  logic [63:0] rsp_rdata;
  logic [3:0]  cpu_irq;

  int checks = 0, fails = 0;
  string cur_tag = "R12";

  always #2 clk = ~clk;

  irq_dist i_irq_dist (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata), .req_cpu_i(req_cpu),
    .set_i(set_v), .clr_i(clr_v), .timer_evt_i(tevt),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .cpu_irq_o(cpu_irq), .timer_irq_o(timer_irq)
  );

  // behavioural reference
  logic [63:0] m_mask [4];
  logic [63:0] m_stat [4];
  logic [63:0] m_pend;
  logic        m_timer;
  logic        e_valid, e_err;
  logic [63:0] e_rdata;
  string       e_tag;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_mask[k]) begin m_mask[k] = '0; m_stat[k] = '0; end
      m_pend = '0; m_timer = 0; e_valid = 0; e_err = 0; e_rdata = '0; e_tag = "R13";
    end else begin
      int idx;
      bit bad;
      logic [63:0] p0, nm, base;
      idx = int'(req_addr[9:6]);
      bad = (req_size != 4'd8) || idx > 9 || (req_write && idx >= 4 && idx <= 8)
            || (req_write && idx == 9 && !req_wdata[4]);
      e_valid = req_valid;
      e_err = req_valid && bad;
      e_tag = cur_tag;
      e_rdata = '0;
      if (req_valid && !bad && !req_write) begin
        if (idx < 4) e_rdata = m_mask[idx];
        else if (idx < 8) e_rdata = m_stat[idx-4];
        else if (idx == 8) e_rdata = m_pend;
        else e_rdata = {59'd0, m_timer, 2'b00, req_cpu};
      end
      p0 = m_pend;
      for (int k = 0; k < 4; k++) begin
        bit wr_k;
        wr_k = req_valid && !bad && req_write && idx == k;
        nm = wr_k ? req_wdata : m_mask[k];
        base = (wr_k && (req_wdata & p0) != 0) ? (req_wdata & p0) : m_stat[k];
        m_stat[k] = (base | (set_v & nm)) & ~clr_v;
        m_mask[k] = nm;
      end
      m_pend = (p0 | set_v) & ~clr_v;
      if (tevt) m_timer = 1;
      else if (req_valid && !bad && req_write && idx == 9) m_timer = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      // R13
      chk("R13", {58'd0, rsp_valid, rsp_err, cpu_irq}, '0);
      chk("R13", {63'd0, timer_irq}, '0);
    end else begin
      logic [3:0] ei;
      for (int k = 0; k < 4; k++) ei[k] = (m_stat[k] != 0);
      chk("R2", {60'd0, cpu_irq}, {60'd0, ei});
      chk("R7", {63'd0, timer_irq}, {63'd0, m_timer});
      chk("R12", {63'd0, rsp_valid}, {63'd0, e_valid});
      if (e_valid) begin
        chk(e_tag, {63'd0, rsp_err}, {63'd0, e_err});
        chk(e_tag, rsp_rdata, e_rdata);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    req_valid = 0; set_v = '0; clr_v = '0; tevt = 0; req_write = 0;
  endtask

  task automatic acc(input bit wr, input int idx, input logic [63:0] d,
                     input string tag, input logic [3:0] sz = 4'd8,
                     input logic [1:0] cpu = 2'd0, input logic [31:0] hi = '0);
    req_valid = 1; req_write = wr; req_wdata = d; req_size = sz; req_cpu = cpu;
    req_addr = hi | (32'(idx) << 6);
    cur_tag = tag;
    cyc();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    acc(0, 8, 0, "R13"); acc(0, 0, 0, "R13"); acc(0, 9, 0, "R13");
    // masks
    acc(1, 0, 64'hFF, "R5"); acc(1, 1, 64'hF00, "R5");
    acc(1, 2, 64'h8000_0000_0000_0000, "R5"); acc(1, 3, 0, "R5");
    acc(0, 1, 0, "R5");
    set_v = 64'h3; cyc();
    acc(0, 4, 0, "R3"); acc(0, 8, 0, "R3");
    set_v = 64'h8000_0000_0000_0000; clr_v = 64'h1; cyc();
    acc(0, 4, 0, "R4"); acc(0, 6, 0, "R3");
    clr_v = 64'h2; cyc();
    acc(0, 4, 0, "R4");
    set_v = 64'h20; clr_v = 64'h20; cyc();
    acc(0, 8, 0, "R4");
    set_v = 64'h100; cyc();
    acc(1, 3, 64'h100, "R5"); acc(0, 7, 0, "R5");
    acc(1, 3, 64'h2, "R5"); acc(0, 7, 0, "R5");
    // mask write and set in the same cycle
    set_v = 64'h200; acc(1, 1, 64'h200, "R3"); acc(0, 5, 0, "R3");
    // timer and misc
    acc(0, 9, 0, "R7", 4'd8, 2'd2);
    tevt = 1; cyc();
    acc(0, 9, 0, "R7", 4'd8, 2'd3);
    acc(1, 9, 64'h1, "R8"); acc(0, 9, 0, "R8");
    acc(1, 9, 64'h10, "R8"); acc(0, 9, 0, "R8");
    tevt = 1; cyc();
    tevt = 1; acc(1, 9, 64'h10, "R8"); acc(0, 9, 0, "R8");
    acc(1, 9, 64'h10, "R8");
    // errors
    acc(0, 0, 0, "R9", 4'd4); acc(0, 8, 0, "R9", 4'd2); acc(1, 0, 64'h5, "R9", 4'd1);
    acc(1, 4, 64'hFFFF, "R10"); acc(1, 8, 64'hFFFF, "R10");
    acc(0, 12, 0, "R10"); acc(1, 15, 64'h1, "R10"); acc(0, 10, 0, "R10");
    acc(1, 1, 64'h0, "R11", 4'd4); acc(0, 1, 0, "R11");
    acc(0, 8, 0, "R11");
    // aliasing
    acc(0, 1, 0, "R6", 4'd8, 2'd0, 32'hABCD_0000 | 32'h3F);
    acc(0, 9, 0, "R6", 4'd8, 2'd1, 32'h0000_FC00 | 32'h11);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) set_v = 64'd1 << $urandom_range(0, 63);
      if (r < 8) set_v |= {$urandom, $urandom} & {$urandom, $urandom};
      if (r >= 15 && r < 30) clr_v = 64'd1 << $urandom_range(0, 63);
      if (r >= 28 && r < 33) clr_v |= {$urandom, $urandom};
      if ($urandom_range(0, 19) == 0) tevt = 1;
      if ($urandom_range(0, 2) == 0) begin
        int ix;
        logic [63:0] d;
        logic [3:0] sz;
        bit wr;
        string t;
        ix = $urandom_range(0, 15);
        if ($urandom_range(0, 3) != 0) ix = $urandom_range(0, 9);
        wr = $urandom_range(0, 1) == 1;
        d = {$urandom, $urandom} & {$urandom, $urandom};
        if (ix == 9 && $urandom_range(0, 1) == 1) d[4] = 1;
        sz = ($urandom_range(0, 9) == 0) ? 4'(1 << $urandom_range(0, 2)) : 4'd8;
        if (sz != 8) t = "R9";
        else if (ix > 9 || (wr && ix >= 4 && ix <= 8)) t = "R10";
        else if (ix == 9) t = wr ? "R8" : "R7";
        else if (ix < 4) t = "R5";
        else t = "R1";
        req_valid = 1; req_write = wr; req_wdata = d; req_size = sz;
        req_cpu = 2'($urandom_range(0, 3));
        req_addr = ({$urandom} & 32'hFFFF_FC3F) | (32'(ix) << 6);
        cur_tag = t;
      end
      cyc();
    end
    repeat (2) cyc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule